// File: doc/BRIEF.md
# Dual-Clock Byte-to-Halfword FIFO

This block carries a byte stream from one clock domain into a consumer that reads 16-bit words on an unrelated clock. The two clocks may differ in frequency or only in phase. Each pair of consecutively accepted bytes is packed into one read word, lowest byte first. The write side sees a full flag; the read side sees an empty flag and a 9-bit count of stored read words.

Write and read pointers count read words. Each pointer crosses to the other domain as a Gray code through two flip-flops, and every flag is computed from local registers only. A flag can therefore lag the true occupancy by a few cycles. The lag is always in the safe direction: full may stay set a little too long and empty may stay set a little too long, but neither clears early.

A small state machine in the write domain packs the bytes. In state PK_LOW it waits for the first byte of a pair. An accepted byte stores that byte and moves the machine to PK_HIGH (transition LOW_TAKEN). In PK_HIGH, an accepted byte writes the completed word to storage, advances the write pointer and returns the machine to PK_LOW (transition PAIR_COMMIT). If no byte is accepted, the machine holds its state. A build-time parameter selects the read mode. RD_STANDARD gives a registered output that updates one read-clock edge after the enable. RD_FWFT places the head word on the output with zero latency.

Top module: `dcfifo_w8r16`

## Requirements
- R1: While the active-low reset is low, and after it is released, the outputs are as follows: rd_empty = 1, wr_full = 0, rd_count = 0. In standard mode rd_data = 0.
- R2: Two consecutive accepted bytes form one read word. The first byte lands in rd_data[7:0] and the second in rd_data[15:8].
- R3: A byte is accepted only on a wr_clk edge where wr_valid = 1 and wr_full = 0. Bytes offered while full are dropped and do not disturb the stored data or the pointers.
- R4: Once the write side has observed 512 bytes (256 words) stored, wr_full is 1. It returns to 0 after the read side frees a word.
- R5: A read happens only on an rd_clk edge where rd_en = 1 and rd_empty = 0. While empty, rd_en leaves the read pointer, rd_count and the standard-mode rd_data unchanged.
- R6: In standard mode, the word taken by a read appears on rd_data right after the rd_clk edge that sampled rd_en, and rd_data holds its value between reads.
- R7: In first-word-fall-through mode, while rd_empty = 0, rd_data already shows the head word before rd_en is asserted. A read advances it to the next word.
- R8: After both sides have been idle for a few cycles, rd_count equals the exact number of stored read words, from 0 to 256.
- R9: A lone byte whose partner has not yet been written is not readable: rd_empty stays 1 and rd_count stays 0.
- R10: Words leave in the order they were written. Each pointer changes by a single Gray-code bit per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Byte offered on wr_data |
| wr_data | input | 8 | Byte to store |
| wr_full | output | 1 | No free byte slot remains (write domain) |
| rd_en | input | 1 | Request to take the head word |
| rd_data | output | 16 | Read word: older byte in [7:0], newer byte in [15:8] |
| rd_empty | output | 1 | No complete word is available (read domain) |
| rd_count | output | 9 | Stored read words, as seen by the read domain |

## Verification
The timing of each result is as follows:
- Standard-mode data is due just after the read-clock edge that samples the enable.
- First-word-fall-through data is due before that edge.
- Both are compared on every read, in the falling-edge half of that same read cycle.

Flags and the count react to the other domain only after a source Gray register and two destination flops, so about three cycles of the observing clock. The bench checks them exactly only after both clocks have run idle for eight cycles each. In that settled state, rd_count must equal the model's queue depth, and rd_empty and wr_full must match the model exactly.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    typedef enum logic [0:0] {
        PK_LOW  = 1'b0,
        PK_HIGH = 1'b1
    } pack_state_t;

    typedef enum logic [0:0] {
        RD_STANDARD = 1'b0,
        RD_FWFT     = 1'b1
    } rd_mode_t;
endpackage

// File: rtl/dcfifo_ptr_xfer.sv
module dcfifo_ptr_xfer #(
    parameter int PW = 9
) (
    input  logic          src_clk,
    input  logic          dst_clk,
    input  logic          rst_n,
    input  logic [PW-1:0] src_bin,
    output logic [PW-1:0] dst_bin
);
    logic [PW-1:0] src_gray;
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) src_gray <= '0;
        else        src_gray <= src_bin ^ (src_bin >> 1);
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= src_gray;
            sync_q <= meta_q;
        end
    end

    assign dst_bin = gray_to_bin(sync_q);

    AST_GRAY_SINGLE_STEP: assert property (@(posedge src_clk) disable iff (!rst_n)
        $onehot0(src_gray ^ $past(src_gray))); // R10
endmodule

// File: rtl/dcfifo_wr_packer.sv
module dcfifo_wr_packer
    import dcfifo_pkg::*;
#(
    parameter int IN_W = 8,
    parameter int AW   = 8
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [IN_W-1:0]   wr_data,
    input  logic [AW:0]       rptr_sync,
    output logic [AW:0]       wptr,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [2*IN_W-1:0] mem_wdata,
    output logic              wr_full
);
    localparam int DEPTH = 1 << AW;
    localparam int PTR_W = AW + 1;

    pack_state_t     st_q, st_nx;
    logic [IN_W-1:0] lo_q;
    logic            accept;
    logic [AW:0]     used_words;

    assign used_words = wptr - rptr_sync;
    assign wr_full    = (used_words == PTR_W'(DEPTH));
    assign accept     = wr_valid & ~wr_full;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            PK_LOW:  if (accept) st_nx = PK_HIGH; // LOW_TAKEN
            PK_HIGH: if (accept) st_nx = PK_LOW;  // PAIR_COMMIT
            default: st_nx = PK_LOW;
        endcase
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) st_q <= PK_LOW;
        else        st_q <= st_nx;
    end

    always_comb begin
        mem_we    = accept && (st_q == PK_HIGH);
        mem_waddr = wptr[AW-1:0];
        mem_wdata = {wr_data, lo_q};
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            wptr <= '0;
        end else begin
            if (accept && (st_q == PK_LOW)) lo_q <= wr_data;
            if (mem_we)                     wptr <= wptr + 1'b1;
        end
    end

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_valid && wr_full) |=> ($stable(wptr) && $stable(st_q))); // R3
    AST_NEVER_OVERFILL: assert property (@(posedge wr_clk) disable iff (!rst_n)
        ({1'b0, used_words} <= (PTR_W+1)'(DEPTH))); // R4
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl
    import dcfifo_pkg::*;
#(
    parameter int       OUT_W = 16,
    parameter int       AW    = 8,
    parameter rd_mode_t MODE  = RD_STANDARD
) (
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [AW:0]      wptr_sync,
    output logic [AW:0]      rptr,
    output logic [AW-1:0]    mem_raddr,
    input  logic [OUT_W-1:0] mem_rdata,
    output logic [OUT_W-1:0] rd_data,
    output logic             rd_empty,
    output logic [AW:0]      rd_count
);
    localparam int DEPTH = 1 << AW;
    localparam int PTR_W = AW + 1;

    logic fire;

    assign rd_count  = wptr_sync - rptr;
    assign rd_empty  = (rd_count == '0);
    assign fire      = rd_en & ~rd_empty;
    assign mem_raddr = rptr[AW-1:0];

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n)    rptr <= '0;
        else if (fire) rptr <= rptr + 1'b1;
    end

    generate
        if (MODE == RD_FWFT) begin : g_fwft
            assign rd_data = mem_rdata;
        end else begin : g_std
            logic [OUT_W-1:0] data_q;
            always_ff @(posedge rd_clk or negedge rst_n) begin
                if (!rst_n)    data_q <= '0;
                else if (fire) data_q <= mem_rdata;
            end
            assign rd_data = data_q;

            AST_STD_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
                !(rd_en && !rd_empty) |=> $stable(rd_data)); // R6
        end
    endgenerate

    AST_NO_READ_WHEN_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_empty |=> $stable(rptr)); // R5
    AST_COUNT_BOUND: assert property (@(posedge rd_clk) disable iff (!rst_n)
        ({1'b0, rd_count} <= (PTR_W+1)'(DEPTH))); // R8
endmodule

// File: rtl/dcfifo_w8r16.sv
module dcfifo_w8r16
    import dcfifo_pkg::*;
#(
    parameter int       IN_W    = 8,
    parameter int       AW      = 8,
    parameter rd_mode_t RD_MODE = RD_STANDARD
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [IN_W-1:0]   wr_data,
    output logic              wr_full,
    input  logic              rd_en,
    output logic [2*IN_W-1:0] rd_data,
    output logic              rd_empty,
    output logic [AW:0]       rd_count
);
    localparam int OUT_W = 2 * IN_W;
    localparam int DEPTH = 1 << AW;
    localparam int PTR_W = AW + 1;

    logic [PTR_W-1:0] wptr, rptr, wptr_sync, rptr_sync;
    logic             mem_we;
    logic [AW-1:0]    mem_waddr, mem_raddr;
    logic [OUT_W-1:0] mem_wdata, mem_rdata;
    logic [OUT_W-1:0] store [DEPTH];

    dcfifo_wr_packer #(.IN_W(IN_W), .AW(AW)) u_wr (
        .wr_clk    (wr_clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rptr_sync (rptr_sync),
        .wptr      (wptr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .wr_full   (wr_full)
    );

    dcfifo_ptr_xfer #(.PW(PTR_W)) u_w2r (
        .src_clk (wr_clk),
        .dst_clk (rd_clk),
        .rst_n   (rst_n),
        .src_bin (wptr),
        .dst_bin (wptr_sync)
    );

    dcfifo_ptr_xfer #(.PW(PTR_W)) u_r2w (
        .src_clk (rd_clk),
        .dst_clk (wr_clk),
        .rst_n   (rst_n),
        .src_bin (rptr),
        .dst_bin (rptr_sync)
    );

    always_ff @(posedge wr_clk) begin
        if (mem_we) store[mem_waddr] <= mem_wdata;
    end

    assign mem_rdata = store[mem_raddr];

    dcfifo_rd_ctrl #(.OUT_W(OUT_W), .AW(AW), .MODE(RD_MODE)) u_rd (
        .rd_clk    (rd_clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wptr_sync (wptr_sync),
        .rptr      (rptr),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .rd_data   (rd_data),
        .rd_empty  (rd_empty),
        .rd_count  (rd_count)
    );
endmodule

// File: tb/dcfifo_w8r16_tb.sv
`timescale 1ns / 100ps
module dcfifo_w8r16_tb;
    import dcfifo_pkg::*;

    logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic        wr_valid = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        full_s, empty_s, full_f, empty_f;
    logic [15:0] data_s, data_f;
    logic [8:0]  count_s, count_f;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [15:0] q[$];
    logic [7:0]  lo_b;
    bit          have_lo = 0;

    always #5    wr_clk = ~wr_clk;
    always #6.5  rd_clk = ~rd_clk;

    dcfifo_w8r16 #(.RD_MODE(RD_STANDARD)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(full_s),
        .rd_en(rd_en), .rd_data(data_s), .rd_empty(empty_s), .rd_count(count_s));

    dcfifo_w8r16 #(.RD_MODE(RD_FWFT)) u_dut_fwft (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(full_f),
        .rd_en(rd_en), .rd_data(data_f), .rd_empty(empty_f), .rd_count(count_f));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Model: bytes pack low-first into words; offers seen while full are dropped.
    task automatic wr_byte(input logic [7:0] b);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_data  = b;
        if (!full_s) begin
            if (have_lo) begin
                q.push_back({b, lo_b});
                have_lo = 0;
            end else begin
                lo_b    = b;
                have_lo = 1;
            end
        end
        @(posedge wr_clk);
        #1 wr_valid = 1'b0;
    endtask

    task automatic rd_word(input bit en, output bit fired);
        logic [15:0] exp;
        logic [15:0] prev_s;
        @(negedge rd_clk);
        rd_en  = en;
        prev_s = data_s;
        #1;
        fired = en && !empty_s;
        exp   = '0;
        if (empty_f != empty_s) chk(0, "R7", "mode empty agreement", empty_f, empty_s);
        if (fired) begin
            exp = q.pop_front();
            chk(data_f == exp, "R7", "fwft head before edge", data_f, exp);
        end
        @(posedge rd_clk);
        #1;
        if (fired) chk(data_s == exp, "R6", "standard data after edge", data_s, exp);
        else if (en) chk(data_s == prev_s, "R5", "standard data hold while empty", data_s, prev_s);
        rd_en = 1'b0;
    endtask

    task automatic settle;
        repeat (8) @(posedge rd_clk);
        repeat (8) @(posedge wr_clk);
        @(negedge rd_clk);
        chk(count_s == 9'(q.size()), "R8", "settled count", count_s, q.size());
        chk(count_f == count_s, "R8", "count agreement", count_f, count_s);
        chk(empty_s == (q.size() == 0), "R9", "settled empty", empty_s, q.size() == 0);
        @(negedge wr_clk);
        chk(full_s == (q.size() == 256), "R4", "settled full", full_s, q.size() == 256);
        chk(full_f == full_s, "R4", "full agreement", full_f, full_s);
    endtask

    initial begin
        #2_000_000;
        chk(0, "R10", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        bit f;
        int got;
        #12;
        chk(empty_s == 1'b1 && full_s == 1'b0 && count_s == 0, "R1", "flags in reset",
            {empty_s, full_s, count_s}, {1'b1, 1'b0, 9'd0});
        chk(data_s == 16'h0, "R1", "standard data in reset", data_s, 0);
        @(negedge wr_clk);
        rst_n = 1'b1;
        settle();

        // Lone byte is not readable, pair packs low-first.
        wr_byte(8'h34);
        settle();
        chk(empty_s == 1'b1 && count_s == 0, "R9", "half word invisible", {empty_s, count_s}, 10'h200);
        wr_byte(8'h12);
        settle();
        @(negedge rd_clk);
        chk(data_f == 16'h1234, "R2", "byte order", data_f, 16'h1234);
        rd_word(1, f);
        settle();

        // Streaming across clocks.
        fork
            for (int i = 0; i < 100; i++) wr_byte(8'(i * 7 + 3));
            begin
                got = 0;
                while (got < 50) begin
                    rd_word(1, f);
                    if (f) got++;
                end
            end
        join
        settle();

        // Fill completely, offer extra bytes while full, then drain.
        for (int i = 0; i < 512; i++) wr_byte(8'(i) ^ 8'h5A);
        settle();
        chk(full_s == 1'b1, "R4", "full at 512 bytes", full_s, 1);
        for (int i = 0; i < 3; i++) wr_byte(8'hEE);
        settle();
        chk(count_s == 9'd256, "R3", "count after writes while full", count_s, 256);
        rd_word(1, f);
        settle();
        chk(full_s == 1'b0, "R4", "full clears after one read", full_s, 0);
        wr_byte(8'h11);
        wr_byte(8'h22);
        got = 0;
        while (q.size() > 0) rd_word(1, f);
        settle();
        chk(count_s == 0, "R10", "drained in order", count_s, 0);

        // Reads while empty are ignored.
        for (int i = 0; i < 5; i++) rd_word(1, f);
        settle();
        chk(count_s == 0 && empty_s == 1'b1, "R5", "empty after idle reads", count_s, 0);
        wr_byte(8'hAB);
        wr_byte(8'hCD);
        settle();
        @(negedge rd_clk);
        chk(data_f == 16'hCDAB, "R5", "pointer kept while empty", data_f, 16'hCDAB);
        rd_word(1, f);
        settle();
        summary();
    end
endmodule